// File: doc/BRIEF.md
# Page Write and Sequential Read Engine

This block runs the data phases of the two memory-access commands of a serial EEPROM-style slave: streaming reads out of, and page programming into, a 64K x 8 storage array that sits outside the block. The front end shifts bits on the serial pins and hands this engine byte-level strobes. These are command pulses carrying the start address, one pulse per received data byte, one pulse each time the previous read byte has been consumed, and a pulse when chip select is released. The last pulse comes with a flag that tells whether the release happened at a legal point, which is the clock-low time directly after the last bit of a byte.

A read fetches bytes from the array one after another with a full-width address counter that wraps from the top address back to zero. A write first gathers up to one page of bytes into a local buffer. The page offset advances modulo the page size, while the page number stays fixed. When chip select is released legally, the write-enable latch was set and the protection query reports no hit, a self-timed programming window starts. At the end of that window the received bytes are copied into the array. A busy flag stays high over the whole window and the copy, and the status logic uses it. In the last busy cycle the engine asks for the write-enable latch to be cleared.

Top module: `pgwr_seqrd_engine`

## Requirements
- R1: Each write data byte goes to address {page, offset}, where page is start address bits [15:7], fixed for the whole command, and offset starts at address bits [6:0] and then increments modulo 128, so 0x7F is followed by 0x00 of the same page.
- R2: When more than 128 bytes are sent, the offset wraps and later bytes replace earlier bytes of the same command, so the last byte received for an offset is the one programmed.
- R3: Programming starts only when cs_rise_i arrives with cs_legal_i high after at least one data byte. Any other release discards the collected bytes and leaves the array unchanged.
- R4: A write command issued while wel_i is low is ignored: its data bytes are dropped, nothing is programmed, and the engine returns to idle at the next cs_rise_i.
- R5: prot_page_o carries the page number (start address bits [15:7]) of the pending write. If prot_hit_i is high when chip select is released, the write is not performed.
- R6: busy_o rises in the cycle after an accepted release and stays high for exactly WR_CYCLES + 128 cycles. Array writes (arr_we_o) happen only while busy_o is high, in the final 128 cycles.
- R7: wel_clr_o is high for exactly one cycle, the last cycle of busy_o, and busy_o is low in the following cycle.
- R8: A read returns the array byte at the start address, then at each following address, one per rd_next_i. Address 0xFFFF is followed by 0x0000. rd_valid_o rises two cycles after the command or the rd_next_i pulse.
- R9: Page offsets that received no byte during a write keep their previous array contents.
- R10: While busy_o is high, read and write commands are ignored: no array read is issued, rd_valid_o stays low, and the engine is idle once busy_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rd_i | input | 1 | Read command pulse, start address on addr_i |
| cmd_wr_i | input | 1 | Write command pulse, start address on addr_i |
| addr_i | input | 16 | Start address of the command |
| wel_i | input | 1 | Current write-enable latch state |
| byte_valid_i | input | 1 | One received write data byte |
| byte_i | input | 8 | Received write data byte |
| rd_next_i | input | 1 | Current read byte consumed, fetch the next |
| cs_rise_i | input | 1 | Chip select released |
| cs_legal_i | input | 1 | Release happened right after a complete byte |
| prot_hit_i | input | 1 | Protection answer for prot_page_o |
| prot_page_o | output | 9 | Page number of the pending write |
| rd_data_o | output | 8 | Current read byte |
| rd_valid_o | output | 1 | rd_data_o holds a fetched byte |
| busy_o | output | 1 | Programming window or array update in progress |
| wel_clr_o | output | 1 | Clear the write-enable latch |
| arr_re_o | output | 1 | Array read strobe, data one cycle later |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 16 | Array address |
| arr_wdata_o | output | 8 | Array write data |
| arr_rdata_i | input | 8 | Array read data |

## Verification
The assertions watch properties that must hold on every cycle. Array writes never occur outside busy and never cross a page. busy only ever rises after a legal release with no protection hit. The latch-clear pulse is always followed by idle. No read activity ever overlaps busy. Other behaviour depends on the data, and only the bench scenarios can show it: the byte values placed at wrapped page offsets, overwriting after more than a page of data, untouched neighbours of a partial page, read rollover at the top address, and commands discarded under a clear latch, an illegal release or a protection hit. The bench compares the exact length of the busy window against its reference model on every clock.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    localparam int ADDR_W_DEF = 16;
    localparam int PG_W_DEF   = 7;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_COLLECT,
        ENG_SKIP,
        ENG_READ
    } eng_state_t;

    typedef enum logic [1:0] {
        RS_OFF,
        RS_ISSUE,
        RS_WAIT,
        RS_HAVE
    } rs_state_t;

    function automatic logic [PG_W_DEF-1:0] offs_next(input logic [PG_W_DEF-1:0] o);
        return o + 1'b1;
    endfunction

endpackage

// File: rtl/pgwr_page_buffer.sv
module pgwr_page_buffer #(
    parameter int PG_W = pgwr_pkg::PG_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [PG_W-1:0] start_i,
    input  logic            wr_i,
    input  logic [7:0]      byte_i,
    input  logic [PG_W-1:0] rd_idx_i,
    output logic [7:0]      rd_byte_o,
    output logic            rd_mask_o,
    output logic            got_o
);
    localparam int PAGE = 1 << PG_W;

    logic [7:0]      mem [PAGE];
    logic [PAGE-1:0] mask_q;
    logic [PG_W-1:0] ptr_q;
    logic            got_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ptr_q  <= '0;
            got_q  <= 1'b0;
        end else if (load_i) begin
            mask_q <= '0;
            ptr_q  <= start_i;
            got_q  <= 1'b0;
        end else if (wr_i) begin
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + 1'b1;
            got_q         <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_i && !load_i) begin
            mem[ptr_q] <= byte_i;
        end
    end

    assign rd_byte_o = mem[rd_idx_i];
    assign rd_mask_o = mask_q[rd_idx_i];
    assign got_o     = got_q;

endmodule

// File: rtl/pgwr_prog_seq.sv
module pgwr_prog_seq #(
    parameter int PG_W      = pgwr_pkg::PG_W_DEF,
    parameter int WR_CYCLES = 500000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    output logic            busy_o,
    output logic            commit_o,
    output logic [PG_W-1:0] idx_o,
    output logic            last_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] CNT_END = CW'(WR_CYCLES - 1);

    logic            prog_q;
    logic            com_q;
    logic [CW-1:0]   cnt_q;
    logic [PG_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= 1'b0;
            com_q  <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
        end else if (prog_q) begin
            if (cnt_q == CNT_END) begin
                prog_q <= 1'b0;
                com_q  <= 1'b1;
                idx_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (com_q) begin
            if (&idx_q) begin
                com_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end else if (start_i) begin
            prog_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    assign busy_o   = prog_q | com_q;
    assign commit_o = com_q;
    assign idx_o    = idx_q;
    assign last_o   = com_q & (&idx_q);

endmodule

// File: rtl/pgwr_read_stream.sv
module pgwr_read_stream #(
    parameter int ADDR_W = pgwr_pkg::ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              next_i,
    input  logic              abort_i,
    input  logic [7:0]        arr_rdata_i,
    output logic              arr_re_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [7:0]        data_o,
    output logic              valid_o
);
    import pgwr_pkg::*;

    rs_state_t         st_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [7:0]        data_q;

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            st_q   <= RS_OFF;
            ptr_q  <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                RS_OFF: if (start_i) begin
                    ptr_q <= addr_i;
                    st_q  <= RS_ISSUE;
                end
                RS_ISSUE: st_q <= RS_WAIT;
                RS_WAIT: begin
                    data_q <= arr_rdata_i;
                    ptr_q  <= ptr_q + 1'b1;
                    st_q   <= RS_HAVE;
                end
                RS_HAVE: if (next_i) st_q <= RS_ISSUE;
                default: st_q <= RS_OFF;
            endcase
        end
    end

    assign arr_re_o   = (st_q == RS_ISSUE);
    assign arr_addr_o = ptr_q;
    assign data_o     = data_q;
    assign valid_o    = (st_q == RS_HAVE);

endmodule

// File: rtl/pgwr_seqrd_engine.sv
module pgwr_seqrd_engine #(
    parameter int ADDR_W    = pgwr_pkg::ADDR_W_DEF,
    parameter int PG_W      = pgwr_pkg::PG_W_DEF,
    parameter int WR_CYCLES = 500000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_rd_i,
    input  logic                   cmd_wr_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   wel_i,
    input  logic                   byte_valid_i,
    input  logic [7:0]             byte_i,
    input  logic                   rd_next_i,
    input  logic                   cs_rise_i,
    input  logic                   cs_legal_i,
    input  logic                   prot_hit_i,
    output logic [ADDR_W-PG_W-1:0] prot_page_o,
    output logic [7:0]             rd_data_o,
    output logic                   rd_valid_o,
    output logic                   busy_o,
    output logic                   wel_clr_o,
    output logic                   arr_re_o,
    output logic                   arr_we_o,
    output logic [ADDR_W-1:0]      arr_addr_o,
    output logic [7:0]             arr_wdata_o,
    input  logic [7:0]             arr_rdata_i
);
    import pgwr_pkg::*;

    localparam int PN_W = ADDR_W - PG_W;

    eng_state_t        st_q;
    logic [PN_W-1:0]   page_q;
    logic              seq_busy, seq_commit, seq_last;
    logic [PG_W-1:0]   seq_idx;
    logic              buf_mask, buf_got;
    logic [7:0]        buf_byte;
    logic              rs_re;
    logic [ADDR_W-1:0] rs_addr;

    logic accept_cmd, buf_load, buf_wr, prog_start, rs_start, rs_abort;

    assign accept_cmd = (st_q == ENG_IDLE) && !seq_busy;
    assign buf_load   = accept_cmd && cmd_wr_i && !cmd_rd_i && wel_i;
    assign rs_start   = accept_cmd && cmd_rd_i;
    assign buf_wr     = (st_q == ENG_COLLECT) && byte_valid_i;
    assign prog_start = (st_q == ENG_COLLECT) && cs_rise_i && cs_legal_i
                        && buf_got && !prot_hit_i;
    assign rs_abort   = (st_q == ENG_READ) && cs_rise_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ENG_IDLE;
            page_q <= '0;
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    if (rs_start) begin
                        st_q <= ENG_READ;
                    end else if (accept_cmd && cmd_wr_i) begin
                        page_q <= addr_i[ADDR_W-1:PG_W];
                        st_q   <= wel_i ? ENG_COLLECT : ENG_SKIP;
                    end
                end
                ENG_COLLECT, ENG_SKIP, ENG_READ: if (cs_rise_i) st_q <= ENG_IDLE;
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    pgwr_page_buffer #(.PG_W(PG_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load_i    (buf_load),
        .start_i   (addr_i[PG_W-1:0]),
        .wr_i      (buf_wr),
        .byte_i    (byte_i),
        .rd_idx_i  (seq_idx),
        .rd_byte_o (buf_byte),
        .rd_mask_o (buf_mask),
        .got_o     (buf_got)
    );

    pgwr_prog_seq #(.PG_W(PG_W), .WR_CYCLES(WR_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (prog_start),
        .busy_o   (seq_busy),
        .commit_o (seq_commit),
        .idx_o    (seq_idx),
        .last_o   (seq_last)
    );

    pgwr_read_stream #(.ADDR_W(ADDR_W)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .start_i     (rs_start),
        .addr_i      (addr_i),
        .next_i      (rd_next_i && (st_q == ENG_READ)),
        .abort_i     (rs_abort),
        .arr_rdata_i (arr_rdata_i),
        .arr_re_o    (rs_re),
        .arr_addr_o  (rs_addr),
        .data_o      (rd_data_o),
        .valid_o     (rd_valid_o)
    );

    assign prot_page_o = page_q;
    assign busy_o      = seq_busy;
    assign wel_clr_o   = seq_last;
    assign arr_re_o    = rs_re;
    assign arr_we_o    = seq_commit && buf_mask;
    assign arr_addr_o  = seq_commit ? {page_q, seq_idx} : rs_addr;
    assign arr_wdata_o = buf_byte;

endmodule

// File: rtl/pgwr_seqrd_engine_chk.sv
module pgwr_seqrd_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int PG_W   = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_rise_i,
    input logic              cs_legal_i,
    input logic              prot_hit_i,
    input logic              busy_o,
    input logic              wel_clr_o,
    input logic              arr_re_o,
    input logic              arr_we_o,
    input logic              rd_valid_o,
    input logic [ADDR_W-1:0] arr_addr_o
);
    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_we_o |-> busy_o); // R6

    AST_WE_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        (arr_we_o && $past(arr_we_o)) |-> (arr_addr_o[ADDR_W-1:PG_W] == $past(arr_addr_o[ADDR_W-1:PG_W]))); // R1

    AST_BUSY_LEGAL_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(cs_rise_i && cs_legal_i)); // R3

    AST_BUSY_NOT_PROT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !$past(prot_hit_i)); // R5

    AST_WELCLR_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        wel_clr_o |=> !busy_o); // R7

    AST_WELCLR_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        wel_clr_o |-> busy_o); // R7

    AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (!arr_re_o && !rd_valid_o)); // R10
endmodule

bind pgwr_seqrd_engine pgwr_seqrd_engine_chk #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_rise_i  (cs_rise_i),
    .cs_legal_i (cs_legal_i),
    .prot_hit_i (prot_hit_i),
    .busy_o     (busy_o),
    .wel_clr_o  (wel_clr_o),
    .arr_re_o   (arr_re_o),
    .arr_we_o   (arr_we_o),
    .rd_valid_o (rd_valid_o),
    .arr_addr_o (arr_addr_o)
);

// File: tb/test_pgwr_seqrd_engine.sv
`timescale 1ns/1ps
module test_pgwr_seqrd_engine;
    localparam int WR   = 40;
    localparam int PAGE = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_rd_i = 0, cmd_wr_i = 0, wel_i = 0;
    logic [15:0] addr_i = '0;
    logic        byte_valid_i = 0, rd_next_i = 0, cs_rise_i = 0, cs_legal_i = 0;
    logic [7:0]  byte_i = '0;
    logic        prot_en = 0;
    logic        prot_hit_i;
    logic [8:0]  prot_page_o;
    logic [7:0]  rd_data_o, arr_wdata_o;
    logic [7:0]  arr_rdata_i = '0;
    logic        rd_valid_o, busy_o, wel_clr_o, arr_re_o, arr_we_o;
    logic [15:0] arr_addr_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    // protection: top quarter of the array (pages 0x180..0x1FF)
    assign prot_hit_i = prot_en && (prot_page_o >= 9'h180);

    pgwr_seqrd_engine #(.WR_CYCLES(WR)) i_pgwr_seqrd_engine (
        .clk(clk), .rst(rst), .cmd_rd_i(cmd_rd_i), .cmd_wr_i(cmd_wr_i),
        .addr_i(addr_i), .wel_i(wel_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .rd_next_i(rd_next_i), .cs_rise_i(cs_rise_i),
        .cs_legal_i(cs_legal_i), .prot_hit_i(prot_hit_i),
        .prot_page_o(prot_page_o), .rd_data_o(rd_data_o),
        .rd_valid_o(rd_valid_o), .busy_o(busy_o), .wel_clr_o(wel_clr_o),
        .arr_re_o(arr_re_o), .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o),
        .arr_wdata_o(arr_wdata_o), .arr_rdata_i(arr_rdata_i)
    );

    // ---------------- array model and expected contents ----------------
    logic [7:0] amem [int];
    logic [7:0] expm [int];

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] arr_val(input logic [15:0] a);
        return amem.exists(int'(a)) ? amem[int'(a)] : pat(a);
    endfunction

    function automatic logic [7:0] exp_val(input logic [15:0] a);
        return expm.exists(int'(a)) ? expm[int'(a)] : pat(a);
    endfunction

    always @(posedge clk) begin
        if (arr_we_o) amem[int'(arr_addr_o)] = arr_wdata_o;
        if (arr_re_o) arr_rdata_i <= arr_val(arr_addr_o);
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // ---------------- cycle reference model for busy / latch clear ----------------
    int       m_mode = 0;      // 0 idle, 1 collecting, 2 skipping, 3 reading
    int       m_left = 0;
    bit       m_got  = 0;
    logic [8:0] m_page = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_left = 0; m_got = 0;
        end else if (m_left > 0) begin
            m_left--;
        end else begin
            case (m_mode)
                0: if (cmd_rd_i) m_mode = 3;
                   else if (cmd_wr_i) begin
                       m_mode = wel_i ? 1 : 2;
                       m_got  = 0;
                       m_page = addr_i[15:7];
                   end
                1: begin
                    if (cs_rise_i) begin
                        if (cs_legal_i && m_got && !(prot_en && m_page >= 9'h180))
                            m_left = WR + PAGE;
                        m_mode = 0;
                    end
                    if (byte_valid_i) m_got = 1;
                end
                default: if (cs_rise_i) m_mode = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(busy_o == (m_left > 0), "R6 busy window", busy_o, m_left > 0);
            chk(wel_clr_o == (m_left == 1), "R7 latch clear", wel_clr_o, m_left == 1);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic pulse_cs(input bit legal);
        @(negedge clk); cs_rise_i = 1; cs_legal_i = legal;
        @(negedge clk); cs_rise_i = 0; cs_legal_i = 0;
    endtask

    task automatic do_read(input logic [15:0] a, input int n, input string req);
        @(negedge clk); cmd_rd_i = 1; addr_i = a;
        @(negedge clk); cmd_rd_i = 0;
        for (int i = 0; i < n; i++) begin
            logic [15:0] ai;
            int w;
            ai = a + 16'(i);
            w = 0;
            while (!rd_valid_o && w < 20) begin @(negedge clk); w++; end
            chk(rd_valid_o && rd_data_o == exp_val(ai), req, rd_data_o, exp_val(ai));
            rd_next_i = 1;
            @(negedge clk); rd_next_i = 0;
        end
        pulse_cs(0);
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] d0,
                            input bit wel, input bit legal, input bit commit, input string req);
        @(negedge clk); cmd_wr_i = 1; addr_i = a; wel_i = wel;
        @(negedge clk); cmd_wr_i = 0;
        for (int i = 0; i < n; i++) begin
            byte_valid_i = 1; byte_i = d0 + 8'(i);
            @(negedge clk); byte_valid_i = 0;
            if (commit) expm[int'({a[15:7], 7'(a[6:0] + 7'(i))})] = d0 + 8'(i);
        end
        pulse_cs(legal);
        chk(busy_o == commit, req, busy_o, commit);
        begin
            int w;
            w = 0;
            while (busy_o && w < WR + PAGE + 20) begin @(negedge clk); w++; end
        end
        @(negedge clk);
    endtask

    // ---------------- scenario ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy_o && !rd_valid_o && !arr_we_o && !wel_clr_o, "reset state", busy_o, 0);

        do_read(16'h1234, 4, "R8 sequential read");
        do_read(16'hFFFE, 4, "R8 rollover 0xFFFF to 0x0000");

        do_write(16'h0310, 3, 8'hC0, 1, 1, 1, "R6 partial page commit");
        do_read(16'h030F, 6, "R9 partial page neighbours and data");

        do_write(16'h057E, 4, 8'h10, 1, 1, 1, "R1 offset wraps in page");
        do_read(16'h057D, 3, "R1 page tail");
        do_read(16'h0500, 3, "R1 page head after wrap");
        do_read(16'h0600, 1, "R1 next page untouched");

        do_write(16'h0700, 130, 8'h00, 1, 1, 1, "R2 overlong page");
        do_read(16'h0700, 4, "R2 overwritten start bytes");
        do_read(16'h077E, 2, "R2 page end bytes");

        do_write(16'h0900, 4, 8'hEE, 1, 0, 0, "R3 illegal release discarded");
        do_read(16'h0900, 4, "R3 array unchanged");
        do_write(16'h0A00, 0, 8'h00, 1, 1, 0, "R3 release with no data byte");

        do_write(16'h0B00, 4, 8'h77, 0, 1, 0, "R4 write with latch clear");
        do_read(16'h0B00, 4, "R4 array unchanged");

        prot_en = 1;
        do_write(16'hC100, 4, 8'h33, 1, 1, 0, "R5 protected page refused");
        do_read(16'hC100, 4, "R5 protected data unchanged");
        do_write(16'h4100, 2, 8'h44, 1, 1, 1, "R5 unprotected page written");
        do_read(16'h4100, 2, "R5 unprotected data");
        prot_en = 0;

        // R10: commands during busy are dropped
        @(negedge clk); cmd_wr_i = 1; addr_i = 16'h0D00; wel_i = 1;
        @(negedge clk); cmd_wr_i = 0;
        byte_valid_i = 1; byte_i = 8'h99;
        @(negedge clk); byte_valid_i = 0;
        expm[int'(16'h0D00)] = 8'h99;
        pulse_cs(1);
        cmd_rd_i = 1; addr_i = 16'h0D00;
        @(negedge clk); cmd_rd_i = 0;
        for (int i = 0; i < 6; i++) begin
            chk(!rd_valid_o && !arr_re_o, "R10 read ignored while busy", rd_valid_o, 0);
            @(negedge clk);
        end
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!rd_valid_o, "R10 idle after busy", rd_valid_o, 0);
        do_read(16'h0D00, 1, "R10 write still committed");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule